// File: doc/BRIEF.md
# Page Program Write Buffer

This block gathers the data bytes of one page-program command ahead of a flash array. A serial front end, not part of this block, reports the start of a program command, each completed byte after the opcode, and the rise of chip select, with a flag saying whether that rise fell partway through a byte. The first bytes after the opcode form the start address, most significant byte first. Every byte after them is stored in a page-sized buffer. The write position starts at the low address bits, advances by one per byte and wraps around inside the same page. A per-offset mask records which page locations the command has touched.

When the command ends cleanly, the block presents the page number, the whole buffer and the mask on a ready/valid array-write port, and holds them until the array accepts. When the command ends too early or on a partial byte, nothing is presented and a one-cycle pulse tells the status logic to clear its write-enable latch.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset, `busy`, `wr_valid` and `wel_clr` are low and `wr_mask` is all zeros.
- R2: The start address is the first ADDR_BYTES received bytes, most significant first. `wr_page` carries its bits above the page offset, and the first data byte lands at the offset given by its low log2(PAGE_BYTES) bits (bits 7..0 by default).
- R3: Each later data byte goes to the next offset. After the last offset of the page the position wraps to offset 0 of the same page, and `wr_page` does not change.
- R4: When more than PAGE_BYTES data bytes arrive, a later byte replaces an earlier one at the same offset, so the buffer holds the most recent PAGE_BYTES bytes.
- R5: Bit i of `wr_mask` is 1 exactly when the command wrote offset i, and byte i of `wr_data` is bits 8i+7..8i. Unwritten offsets have mask 0, so those page locations stay unchanged.
- R6: A `cmd_end` that arrives before all address bytes and at least one data byte have been received causes no commit.
- R7: A `cmd_end` with `end_partial` high causes no commit, even if complete bytes came before it.
- R8: An aborted command raises `wel_clr` for exactly one cycle, in the cycle after `cmd_end`. A committed command never raises it.
- R9: A commit raises `wr_valid` and `busy` in the cycle after `cmd_end`. Both stay high, with page, data and mask unchanged, until the cycle in which `wr_ready` is high, and both are low in the next cycle.
- R10: While `busy` is high, `cmd_start`, `rx_valid` and `cmd_end` have no effect. A `cmd_end` outside a command has no effect.
- R11: Each new command starts with an empty mask. Offsets written by an earlier command do not appear in its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Pulse: a page-program opcode has been decoded |
| rx_valid | input | 1 | Pulse: a complete byte has been received |
| rx_byte | input | 8 | The received byte |
| cmd_end | input | 1 | Pulse: chip select has risen |
| end_partial | input | 1 | With `cmd_end`: the rise was not on a byte boundary |
| wr_valid | output | 1 | Array-write request |
| wr_ready | input | 1 | Array accepts the request |
| wr_page | output | 8*ADDR_BYTES-log2(PAGE_BYTES) | Page number to program |
| wr_data | output | 8*PAGE_BYTES | Buffer contents, offset i in bits 8i+7..8i |
| wr_mask | output | PAGE_BYTES | Offsets written by the command |
| busy | output | 1 | Commit pending on the array port |
| wel_clr | output | 1 | Pulse: clear the write-enable latch (abort) |

## Verification
A broken write pointer shows as soon as the first commit presents data: a misplaced byte or mask bit puts `wr_data` or `wr_mask` at the wrong offset, and a pointer that carries into the page number shows in `wr_page`. A wrong byte count or a mishandled boundary flag turns a commit into an abort, or the reverse, one cycle after `cmd_end`, visible on `wr_valid` and `wel_clr`. Commands accepted during a stall, or a mask left uncleared, corrupt the held payload or the next command's mask at its next commit.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic [1:0] {
      PP_IDLE = 2'd0,
      PP_FILL = 2'd1,
      PP_HAND = 2'd2
   } pp_state_e;
endpackage

// File: rtl/pp_addr_track.sv
module pp_addr_track #(
   parameter int ADDR_BYTES = 3,
   parameter int OFF_W      = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clear,
   input  logic                            fill,
   input  logic                            rx_valid,
   input  logic [7:0]                      rx_byte,
   output logic                            addr_done,
   output logic                            have_data,
   output logic                            wr_en,
   output logic [OFF_W-1:0]                wr_off,
   output logic [8*ADDR_BYTES-OFF_W-1:0]   page
);
   localparam int ADDR_W = 8 * ADDR_BYTES;
   localparam int CNT_W  = $clog2(ADDR_BYTES + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic              data_q;

   assign addr_done = (cnt_q == CNT_W'(ADDR_BYTES));
   assign wr_en     = fill & rx_valid & addr_done;
   assign have_data = data_q;
   assign wr_off    = addr_q[OFF_W-1:0];
   assign page      = addr_q[ADDR_W-1:OFF_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         addr_q <= '0;
         data_q <= 1'b0;
      end else if (clear) begin
         cnt_q  <= '0;
         data_q <= 1'b0;
      end else if (fill && rx_valid) begin
         if (!addr_done) begin
            addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
            cnt_q  <= cnt_q + 1'b1;
         end else begin
            addr_q[OFF_W-1:0] <= addr_q[OFF_W-1:0] + 1'b1;
            data_q            <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pp_page_store.sv
module pp_page_store #(
   parameter int PAGE_BYTES = 256,
   parameter int OFF_W      = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      wr_en,
   input  logic [OFF_W-1:0]          wr_off,
   input  logic [7:0]                wr_byte,
   output logic [8*PAGE_BYTES-1:0]   data,
   output logic [PAGE_BYTES-1:0]     mask
);
   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
      localparam logic [OFF_W-1:0] IDX = OFF_W'(i);
      logic       hit;
      logic [7:0] byte_q;
      logic       used_q;

      assign hit = wr_en && (wr_off == IDX);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            byte_q <= 8'hFF;
            used_q <= 1'b0;
         end else begin
            if (hit) byte_q <= wr_byte;
            if (clear)    used_q <= 1'b0;
            else if (hit) used_q <= 1'b1;
         end
      end

      assign data[8*i +: 8] = byte_q;
      assign mask[i]        = used_q;
   end
endmodule

// File: rtl/pp_commit_ctrl.sv
module pp_commit_ctrl
   import pp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_start,
   input  logic cmd_end,
   input  logic end_partial,
   input  logic wr_ready,
   input  logic have_data,
   input  logic byte_now,
   output logic fill,
   output logic clear,
   output logic hand,
   output logic wel_clr
);
   pp_state_e state_q, state_d;
   logic      commit_ok;
   logic      abort_d;
   logic      wel_q;

   assign commit_ok = (have_data | byte_now) & ~end_partial;
   assign fill      = (state_q == PP_FILL);
   assign hand      = (state_q == PP_HAND);
   assign clear     = cmd_start && ((state_q == PP_IDLE) ||
                                    ((state_q == PP_FILL) && !cmd_end));
   assign wel_clr   = wel_q;

   always_comb begin
      state_d = state_q;
      abort_d = 1'b0;
      unique case (state_q)
         PP_IDLE: if (cmd_start) state_d = PP_FILL;
         PP_FILL: begin
            if (cmd_end) begin
               state_d = commit_ok ? PP_HAND : PP_IDLE;
               abort_d = !commit_ok;
            end
         end
         PP_HAND: if (wr_ready) state_d = PP_IDLE;
         default: state_d = PP_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PP_IDLE;
         wel_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         wel_q   <= abort_d;
      end
   end
endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
   parameter int PAGE_BYTES = 256,
   parameter int ADDR_BYTES = 3
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        cmd_start,
   input  logic                                        rx_valid,
   input  logic [7:0]                                  rx_byte,
   input  logic                                        cmd_end,
   input  logic                                        end_partial,
   output logic                                        wr_valid,
   input  logic                                        wr_ready,
   output logic [8*ADDR_BYTES-$clog2(PAGE_BYTES)-1:0]  wr_page,
   output logic [8*PAGE_BYTES-1:0]                     wr_data,
   output logic [PAGE_BYTES-1:0]                       wr_mask,
   output logic                                        busy,
   output logic                                        wel_clr
);
   localparam int OFF_W  = $clog2(PAGE_BYTES);
   localparam int ADDR_W = 8 * ADDR_BYTES;

   if (PAGE_BYTES < 2 || (1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (ADDR_BYTES < 2 || OFF_W >= ADDR_W) begin : g_bad_addr
      $error("ADDR_BYTES must be at least 2 and wider than the page offset");
   end

   logic             fill, clear, hand;
   logic             addr_done, have_data, wr_en;
   logic [OFF_W-1:0] wr_off;

   pp_commit_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .cmd_end     (cmd_end),
      .end_partial (end_partial),
      .wr_ready    (wr_ready),
      .have_data   (have_data),
      .byte_now    (wr_en),
      .fill        (fill),
      .clear       (clear),
      .hand        (hand),
      .wel_clr     (wel_clr)
   );

   pp_addr_track #(.ADDR_BYTES(ADDR_BYTES), .OFF_W(OFF_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .fill      (fill),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .addr_done (addr_done),
      .have_data (have_data),
      .wr_en     (wr_en),
      .wr_off    (wr_off),
      .page      (wr_page)
   );

   pp_page_store #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .wr_en   (wr_en),
      .wr_off  (wr_off),
      .wr_byte (rx_byte),
      .data    (wr_data),
      .mask    (wr_mask)
   );

   assign wr_valid = hand;
   assign busy     = hand;
endmodule

// File: rtl/page_prog_buffer_chk.sv
module page_prog_buffer_chk #(
   parameter int PAGE_BYTES = 256,
   parameter int ADDR_BYTES = 3
) (
   input logic                                        clk,
   input logic                                        rst_n,
   input logic                                        cmd_end,
   input logic                                        end_partial,
   input logic                                        wr_valid,
   input logic                                        wr_ready,
   input logic [8*ADDR_BYTES-$clog2(PAGE_BYTES)-1:0]  wr_page,
   input logic [8*PAGE_BYTES-1:0]                     wr_data,
   input logic [PAGE_BYTES-1:0]                       wr_mask,
   input logic                                        wel_clr
);
   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid); // R9
   AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> $stable(wr_page) && $stable(wr_data) && $stable(wr_mask)); // R9
   AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready |=> !wr_valid); // R9
   AST_COMMIT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> (wr_mask != '0)); // R5
   AST_PARTIAL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_end && end_partial && !wr_valid |=> !wr_valid); // R7
   AST_ABORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clr |-> !wr_valid); // R8
   AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clr |=> !wel_clr); // R8
endmodule

bind page_prog_buffer page_prog_buffer_chk #(
   .PAGE_BYTES (PAGE_BYTES),
   .ADDR_BYTES (ADDR_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_end     (cmd_end),
   .end_partial (end_partial),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .wr_page     (wr_page),
   .wr_data     (wr_data),
   .wr_mask     (wr_mask),
   .wel_clr     (wel_clr)
);

// File: tb/sim_page_prog_buffer.sv
`timescale 1ns/1ps
module sim_page_prog_buffer;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_start = 1'b0, rx_valid = 1'b0, cmd_end = 1'b0, end_partial = 1'b0;
   logic [7:0]    rx_byte = 8'h00;
   logic          wr_ready = 1'b0;
   logic          wr_valid, busy, wel_clr;
   logic [15:0]   wr_page;
   logic [2047:0] wr_data;
   logic [255:0]  wr_mask;

   int total = 0, fails = 0;
   bit done = 0;

   logic [7:0]   emem [256];
   logic [255:0] emask;
   logic [15:0]  epage;

   page_prog_buffer u0 (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .cmd_end(cmd_end), .end_partial(end_partial),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_page(wr_page),
      .wr_data(wr_data), .wr_mask(wr_mask), .busy(busy), .wel_clr(wel_clr)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] exp_off(input logic [7:0] start, input int idx);
      return 8'(int'(start) + idx);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      rx_valid = 1'b1; rx_byte = b;
      tick();
      rx_valid = 1'b0;
   endtask

   task automatic check_payload(input string req);
      int bad = 0;
      logic [7:0] fa = 8'h00, fe = 8'h00;
      for (int i = 0; i < 256; i++)
         if (emask[i] && wr_data[8*i +: 8] !== emem[i]) begin
            if (bad == 0) begin fa = wr_data[8*i +: 8]; fe = emem[i]; end
            bad++;
         end
      chk(bad == 0, req, 64'(fa), 64'(fe));
      chk(wr_mask === emask, "R5", 64'(wr_mask[63:0]), 64'(emask[63:0]));
      chk(wr_page === epage, "R2", 64'(wr_page), 64'(epage));
   endtask

   // naddr: address bytes sent (0..3); nbytes: data bytes after a full address
   task automatic do_cmd(input logic [23:0] a, input int naddr, input int nbytes,
                         input bit partial, input int stall, input string req);
      bit commit;
      emask = '0;
      cmd_start = 1'b1; tick(); cmd_start = 1'b0;
      for (int k = 0; k < naddr; k++) send_byte(a[23-8*k -: 8]);
      if (naddr == 3)
         for (int j = 0; j < nbytes; j++) begin
            logic [7:0] d = 8'($urandom);
            logic [7:0] o = exp_off(a[7:0], j);
            emem[o] = d; emask[o] = 1'b1;
            send_byte(d);
         end
      commit = (naddr == 3) && (nbytes >= 1) && !partial;
      cmd_end = 1'b1; end_partial = partial;
      tick();
      cmd_end = 1'b0; end_partial = 1'b0;
      if (commit) begin
         epage = a[23:8];
         chk(wr_valid === 1'b1 && busy === 1'b1, "R9", {wr_valid, busy}, 2'b11);
         chk(wel_clr === 1'b0, "R8", wel_clr, 0);
         check_payload(req);
         for (int s = 0; s < stall; s++) begin
            if (s == 0) begin
               cmd_start = 1'b1; rx_valid = 1'b1; rx_byte = 8'($urandom);
               cmd_end = 1'b1; end_partial = 1'($urandom);
            end
            tick();
            cmd_start = 1'b0; rx_valid = 1'b0; cmd_end = 1'b0; end_partial = 1'b0;
            chk(wr_valid === 1'b1 && busy === 1'b1, "R9", {wr_valid, busy}, 2'b11);
            check_payload("R10");
         end
         wr_ready = 1'b1; tick(); wr_ready = 1'b0;
         chk(wr_valid === 1'b0 && busy === 1'b0, "R9", {wr_valid, busy}, 2'b00);
         chk(wel_clr === 1'b0, "R10", wel_clr, 0);
         cmd_end = 1'b1; tick(); cmd_end = 1'b0;
         chk(wr_valid === 1'b0 && wel_clr === 1'b0, "R10", {wr_valid, wel_clr}, 2'b00);
      end else begin
         chk(wr_valid === 1'b0 && busy === 1'b0, req, {wr_valid, busy}, 2'b00);
         chk(wel_clr === 1'b1, "R8", wel_clr, 1);
         tick();
         chk(wel_clr === 1'b0 && wr_valid === 1'b0, "R8", {wel_clr, wr_valid}, 2'b00);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      total++; fails++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd2718);
      for (int i = 0; i < 256; i++) emem[i] = 8'hFF;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(busy === 1'b0 && wr_valid === 1'b0 && wel_clr === 1'b0, "R1",
          {busy, wr_valid, wel_clr}, 3'b000);
      chk(wr_mask === '0, "R1", 64'(wr_mask[63:0]), 0);
      // R2 aligned start, R3 wrap at page end
      do_cmd(24'h012300, 3, 5, 0, 2, "R2");
      do_cmd(24'h0456FE, 3, 3, 0, 1, "R3");
      // R4 more than a page: last 256 kept
      do_cmd(24'h070910, 3, 300, 0, 3, "R4");
      // R11 next command mask only its own bytes
      do_cmd(24'h070920, 3, 1, 0, 0, "R11");
      // R6 early ends
      do_cmd(24'h001122, 2, 0, 0, 0, "R6");
      do_cmd(24'h001122, 3, 0, 0, 0, "R6");
      do_cmd(24'h001122, 0, 0, 0, 0, "R6");
      // R7 partial byte at end
      do_cmd(24'h0033F0, 3, 4, 1, 0, "R7");
      // random mix
      for (int n = 0; n < 25; n++) begin
         int kind = int'($urandom_range(0, 9));
         logic [23:0] a = 24'($urandom);
         if (kind == 0)      do_cmd(a, int'($urandom_range(0, 2)), 0, 0, 0, "R6");
         else if (kind == 1) do_cmd(a, 3, int'($urandom_range(1, 20)), 1, 0, "R7");
         else                do_cmd(a, 3, int'($urandom_range(1, 40)), 0,
                                    int'($urandom_range(0, 4)), "R3");
      end
      finish_up();
   end
endmodule